// File: doc/BRIEF.md
# I2C master command sequencer

This block controls the transaction flow of an I2C master. Software drives it through three command bits, start, restart and stop, which are written by one-cycle set strobes. From these bits the sequencer decides which bus condition comes next and when each bit clears. It fetches the address byte and the data bytes from a transmit FIFO and pushes received bytes into a receive FIFO. For reads it counts against a programmed byte count. The serial engine that toggles SCL and SDA is not part of the block. It is reached through a byte-level request/done handshake: the sequencer holds `eng_req` together with an operation code, and the engine answers with a one-cycle `eng_done` that carries the slave's ACK or NACK and, for reads, the received byte.

The controller is one state machine:

| State | Role |
|---|---|
| IDLE | Waits for the start bit and a free bus. |
| BUSY | Holds a request to the engine until it completes. |
| FETCH | Waits for an address byte in the transmit FIFO. |
| WR_NEXT | Sends the next data byte, or pauses when the FIFO is empty. |
| RD_NEXT | Issues the next read with ACK or NACK chosen. |
| FINISH | Picks a repeated START or a STOP. |
| ERR_STOP | Issues the STOP that follows a NACK. |

The transitions are:

- Go (IDLE→BUSY).
- Condition done (BUSY→FETCH).
- Address sent (BUSY→WR_NEXT, RD_NEXT or FINISH).
- Byte sent (BUSY→WR_NEXT).
- Byte read (BUSY→RD_NEXT or FINISH).
- Refused (BUSY→ERR_STOP).
- Stop done (BUSY→IDLE).
- Drained (WR_NEXT→FINISH).
- Resume (FINISH→BUSY).
- Abort (any→IDLE when master mode drops; from BUSY, abort happens only after the engine completes).

Three sticky flags report progress: done, address-acknowledged and error.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A START is requested (operation code 0) only when `bus_busy` is low. While the bus is busy, a set start bit stays pending and no request is raised.
- R2: When start and restart are set together, a START is issued first. A repeated START (code 1) follows at the end of that transaction.
- R3: When restart and stop are both pending at the end of a transaction, a repeated START is issued and no STOP (code 2). Both bits read 0 from the cycle in which the repeated START request rises.
- R4: When start, restart and stop are all set at once, the order is START, then repeated START at the end of the first transaction. The stop bit is cleared at that point and no STOP is produced.
- R5: The start bit stays set through repeated STARTs and pauses. It clears only when a STOP has completed.
- R6: The address byte's bit 0 set to 1 selects a read. A read performs exactly the programmed count of byte reads (code 4). `eng_ack` is 1 (ACK) on every read except the last, which gets 0 (NACK). Each byte is pushed to the receive FIFO, and done is raised after the last one. A count of 0 raises done right after the address is acknowledged, with no reads.
- R7: On a write (code 3), if the transmit FIFO is empty at a byte boundary, the sequencer waits without requesting anything and without raising done. It waits until a byte arrives or restart or stop is set.
- R8: When the transmit FIFO is empty and restart or stop is pending, done is raised and the selected condition is issued.
- R9: An ACK to the address byte sets the address-acknowledged flag. A NACK to it does not.
- R10: While `master_en` is low, the start, restart and stop bits read 0 and set strobes have no effect.
- R11: A NACK to an address or data byte sets the error flag and issues a STOP with no further bytes. All command bits are clear once that STOP completes.
- R12: The done, address-ack and error flags (`flag_clr` bits 0, 1 and 2) are sticky. Each clears only when its own clear bit is strobed. All are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Master mode enable |
| start_set | input | 1 | Strobe that sets the start bit |
| restart_set | input | 1 | Strobe that sets the restart bit |
| stop_set | input | 1 | Strobe that sets the stop bit |
| bus_busy | input | 1 | Another master holds the bus |
| rx_count | input | CNT_W | Number of bytes to read |
| flag_clr | input | 3 | Write-one-to-clear strobes: done, address-ack, error |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | DATA_W | Head of the transmit FIFO |
| tx_pop | output | 1 | Pops the transmit FIFO head |
| rx_push | output | 1 | Pushes `rx_data` into the receive FIFO |
| rx_data | output | DATA_W | Received byte |
| eng_req | output | 1 | Request to the byte engine |
| eng_op | output | 3 | Operation code: 0 START, 1 repeated START, 2 STOP, 3 write, 4 read |
| eng_wdata | output | DATA_W | Byte to write |
| eng_ack | output | 1 | Acknowledge to send after a read (1 = ACK) |
| eng_done | input | 1 | Engine completed the request |
| eng_nack | input | 1 | Slave refused the written byte |
| eng_rdata | input | DATA_W | Byte read by the engine |
| cmd_start | output | 1 | Start bit |
| cmd_restart | output | 1 | Restart bit |
| cmd_stop | output | 1 | Stop bit |
| done_flag | output | 1 | Transfer done flag |
| addr_ack_flag | output | 1 | Address acknowledged flag |
| err_flag | output | 1 | NACK error flag |

## Verification
The bench builds the block with an 8-bit data path and a 4-bit receive count. This keeps counts of 0, 1 and 3 and the final-byte NACK boundary within a few engine round trips. A modelled byte engine answers each request after a short fixed latency. That latency leaves long enough windows to observe the command bits between a repeated START and the following address byte, and to see the empty-FIFO pause hold for many cycles.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } bus_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BUSY,
        S_FETCH,
        S_WR_NEXT,
        S_RD_NEXT,
        S_FINISH,
        S_ERR_STOP
    } seq_state_e;

    localparam int CMD_START   = 0;
    localparam int CMD_RESTART = 1;
    localparam int CMD_STOP    = 2;
    localparam int NUM_CMDS    = 3;

    localparam int FLAG_DONE   = 0;
    localparam int FLAG_AACK   = 1;
    localparam int FLAG_ERR    = 2;
    localparam int NUM_FLAGS   = 3;
endpackage

// File: rtl/seq_cmd_bits.sv
module seq_cmd_bits
    import i2cseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                master_en,
    input  logic [NUM_CMDS-1:0] set_i,
    input  logic [NUM_CMDS-1:0] clr_i,
    output logic [NUM_CMDS-1:0] bits_o
);
    logic [NUM_CMDS-1:0] bits_q;

    for (genvar i = 0; i < NUM_CMDS; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bits_q[i] <= 1'b0;
            end else if (!master_en || clr_i[i]) begin
                bits_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                bits_q[i] <= 1'b1;
            end
        end
    end

    assign bits_o = bits_q;

    // R10: master mode off leaves every command bit clear on the next cycle
    p_master_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (bits_q == '0));
endmodule

// File: rtl/seq_flags.sv
module seq_flags
    import i2cseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic [NUM_FLAGS-1:0] clr_i,
    output logic [NUM_FLAGS-1:0] flags_o
);
    logic [NUM_FLAGS-1:0] flags_q;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                flags_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                flags_q[i] <= 1'b0;
            end
        end
    end

    assign flags_o = flags_q;

    // R12: a flag only falls when its own clear bit was strobed
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags_q) & ~$past(clr_i) & ~flags_q) == '0));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import i2cseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 master_en,
    input  logic [NUM_CMDS-1:0]  cmd_bits,
    input  logic                 bus_busy,
    input  logic [CNT_W-1:0]     rx_count,
    input  logic                 tx_empty,
    input  logic [DATA_W-1:0]    tx_data,
    output logic                 tx_pop,
    output logic                 rx_push,
    output logic                 eng_req,
    output bus_op_e              eng_op,
    output logic [DATA_W-1:0]    eng_wdata,
    output logic                 eng_ack,
    input  logic                 eng_done,
    input  logic                 eng_nack,
    output logic [NUM_CMDS-1:0]  cmd_clr,
    output logic [NUM_FLAGS-1:0] flag_set
);
    localparam logic [CNT_W-1:0] LAST_ONE = CNT_W'(1);

    seq_state_e        state_q, state_d;
    bus_op_e           op_q, op_d;
    logic [DATA_W-1:0] wdata_q, wdata_d;
    logic              ack_q, ack_d;
    logic              is_addr_q, is_addr_d;
    logic              rd_q, rd_d;
    logic [CNT_W-1:0]  remain_q, remain_d;

    logic want_start, want_restart, want_stop;
    assign want_start   = cmd_bits[CMD_START];
    assign want_restart = cmd_bits[CMD_RESTART];
    assign want_stop    = cmd_bits[CMD_STOP];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            op_q      <= OP_START;
            wdata_q   <= '0;
            ack_q     <= 1'b0;
            is_addr_q <= 1'b0;
            rd_q      <= 1'b0;
            remain_q  <= '0;
        end else begin
            state_q   <= state_d;
            op_q      <= op_d;
            wdata_q   <= wdata_d;
            ack_q     <= ack_d;
            is_addr_q <= is_addr_d;
            rd_q      <= rd_d;
            remain_q  <= remain_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        op_d      = op_q;
        wdata_d   = wdata_q;
        ack_d     = ack_q;
        is_addr_d = is_addr_q;
        rd_d      = rd_q;
        remain_d  = remain_q;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        cmd_clr   = '0;
        flag_set  = '0;

        if (!master_en && state_q != S_BUSY) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (want_start && !bus_busy) begin
                        op_d    = OP_START;
                        state_d = S_BUSY;
                    end
                end
                S_BUSY: begin
                    if (eng_done) begin
                        unique case (op_q)
                            OP_START, OP_RESTART: state_d = S_FETCH;
                            OP_STOP: begin
                                cmd_clr = '1;
                                state_d = S_IDLE;
                            end
                            OP_WRITE: begin
                                if (eng_nack) begin
                                    flag_set[FLAG_ERR] = 1'b1;
                                    state_d = S_ERR_STOP;
                                end else if (is_addr_q) begin
                                    flag_set[FLAG_AACK] = 1'b1;
                                    if (!rd_q) begin
                                        state_d = S_WR_NEXT;
                                    end else if (remain_q == '0) begin
                                        flag_set[FLAG_DONE] = 1'b1;
                                        state_d = S_FINISH;
                                    end else begin
                                        state_d = S_RD_NEXT;
                                    end
                                end else begin
                                    state_d = S_WR_NEXT;
                                end
                            end
                            OP_READ: begin
                                rx_push  = 1'b1;
                                remain_d = remain_q - LAST_ONE;
                                if (remain_q == LAST_ONE) begin
                                    flag_set[FLAG_DONE] = 1'b1;
                                    state_d = S_FINISH;
                                end else begin
                                    state_d = S_RD_NEXT;
                                end
                            end
                            default: state_d = S_IDLE;
                        endcase
                        if (!master_en) begin
                            state_d = S_IDLE;
                        end
                    end
                end
                S_FETCH: begin
                    if (!tx_empty) begin
                        tx_pop    = 1'b1;
                        op_d      = OP_WRITE;
                        wdata_d   = tx_data;
                        is_addr_d = 1'b1;
                        rd_d      = tx_data[0];
                        remain_d  = rx_count;
                        state_d   = S_BUSY;
                    end
                end
                S_WR_NEXT: begin
                    if (!tx_empty) begin
                        tx_pop    = 1'b1;
                        op_d      = OP_WRITE;
                        wdata_d   = tx_data;
                        is_addr_d = 1'b0;
                        state_d   = S_BUSY;
                    end else if (want_restart || want_stop) begin
                        flag_set[FLAG_DONE] = 1'b1;
                        state_d = S_FINISH;
                    end
                end
                S_RD_NEXT: begin
                    op_d      = OP_READ;
                    ack_d     = (remain_q != LAST_ONE);
                    is_addr_d = 1'b0;
                    state_d   = S_BUSY;
                end
                S_FINISH: begin
                    if (want_restart) begin
                        cmd_clr[CMD_RESTART] = 1'b1;
                        cmd_clr[CMD_STOP]    = 1'b1;
                        op_d    = OP_RESTART;
                        state_d = S_BUSY;
                    end else if (want_stop) begin
                        op_d    = OP_STOP;
                        state_d = S_BUSY;
                    end
                end
                S_ERR_STOP: begin
                    op_d    = OP_STOP;
                    state_d = S_BUSY;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    assign eng_req   = (state_q == S_BUSY);
    assign eng_op    = op_q;
    assign eng_wdata = wdata_q;
    assign eng_ack   = ack_q;

    // R1: a START request only rises after a cycle with the bus free
    p_start_bus_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eng_req) && op_q == OP_START) |-> $past(!bus_busy));
    // R7: the transmit FIFO is never popped while empty
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
    // R6: the final read of a count carries a NACK
    p_last_read_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && op_q == OP_READ && remain_q == LAST_ONE) |-> !ack_q);
    // R6: bytes are pushed only on completion of a read
    p_push_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (eng_req && eng_done && op_q == OP_READ));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2cseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              start_set,
    input  logic              restart_set,
    input  logic              stop_set,
    input  logic              bus_busy,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [2:0]        flag_clr,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic [DATA_W-1:0] eng_wdata,
    output logic              eng_ack,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic              cmd_start,
    output logic              cmd_restart,
    output logic              cmd_stop,
    output logic              done_flag,
    output logic              addr_ack_flag,
    output logic              err_flag
);
    logic [NUM_CMDS-1:0]  cmd_bits, cmd_set, cmd_clr;
    logic [NUM_FLAGS-1:0] flags, flag_set;
    bus_op_e              op;

    assign cmd_set[CMD_START]   = start_set;
    assign cmd_set[CMD_RESTART] = restart_set;
    assign cmd_set[CMD_STOP]    = stop_set;

    seq_cmd_bits u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .set_i     (cmd_set),
        .clr_i     (cmd_clr),
        .bits_o    (cmd_bits)
    );

    seq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .flags_o (flags)
    );

    seq_fsm #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .cmd_bits  (cmd_bits),
        .bus_busy  (bus_busy),
        .rx_count  (rx_count),
        .tx_empty  (tx_empty),
        .tx_data   (tx_data),
        .tx_pop    (tx_pop),
        .rx_push   (rx_push),
        .eng_req   (eng_req),
        .eng_op    (op),
        .eng_wdata (eng_wdata),
        .eng_ack   (eng_ack),
        .eng_done  (eng_done),
        .eng_nack  (eng_nack),
        .cmd_clr   (cmd_clr),
        .flag_set  (flag_set)
    );

    assign eng_op        = op;
    assign rx_data       = eng_rdata;
    assign cmd_start     = cmd_bits[CMD_START];
    assign cmd_restart   = cmd_bits[CMD_RESTART];
    assign cmd_stop      = cmd_bits[CMD_STOP];
    assign done_flag     = flags[FLAG_DONE];
    assign addr_ack_flag = flags[FLAG_AACK];
    assign err_flag      = flags[FLAG_ERR];

    // R3: restart and stop bits are both clear once a repeated START request rises
    p_restart_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eng_req) && eng_op == 3'd1) |-> (!cmd_restart && !cmd_stop));
endmodule

// File: tb/tb_i2c_cmd_seq.sv
module tb_i2c_cmd_seq;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] data;
        logic       ack;
        logic       nack;
        logic [7:0] rdata;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b1;
    logic start_set = 1'b0, restart_set = 1'b0, stop_set = 1'b0;
    logic bus_busy = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [2:0] flag_clr = '0;
    logic tx_empty;
    logic [7:0] tx_data;
    logic tx_pop, rx_push, eng_req, eng_ack;
    logic [7:0] rx_data, eng_wdata;
    logic [2:0] eng_op;
    logic eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0] eng_rdata = '0;
    logic cmd_start, cmd_restart, cmd_stop, done_flag, addr_ack_flag, err_flag;

    int compared = 0;
    int mismatched = 0;
    int ops_seen = 0;

    exp_t  expq[$];
    string tagq[$];

    logic [7:0] txm [0:15];
    logic [4:0] twr = '0;
    logic [4:0] trd = '0;
    logic [7:0] rxlog [0:15];
    int rxn = 0;

    always #5 clk = ~clk;

    i2c_cmd_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en),
        .start_set(start_set), .restart_set(restart_set), .stop_set(stop_set),
        .bus_busy(bus_busy), .rx_count(rx_count), .flag_clr(flag_clr),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data),
        .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_ack(eng_ack),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
        .cmd_start(cmd_start), .cmd_restart(cmd_restart), .cmd_stop(cmd_stop),
        .done_flag(done_flag), .addr_ack_flag(addr_ack_flag), .err_flag(err_flag)
    );

    // transmit FIFO model
    assign tx_empty = (twr == trd);
    assign tx_data  = txm[trd[3:0]];
    always @(posedge clk) if (tx_pop) trd <= trd + 5'd1;

    // receive FIFO log
    always @(posedge clk) if (rx_push) begin
        rxlog[rxn[3:0]] <= rx_data;
        rxn <= rxn + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_op(input logic [2:0] op, input logic [7:0] data, input logic ack,
                             input logic nack, input logic [7:0] rdata, input string tag);
        exp_t e;
        e.op = op; e.data = data; e.ack = ack; e.nack = nack; e.rdata = rdata;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        txm[twr[3:0]] = b;
        twr = twr + 5'd1;
    endtask

    task automatic pulse_cmd(input logic s, input logic r, input logic p);
        @(negedge clk);
        start_set = s; restart_set = r; stop_set = p;
        @(negedge clk);
        start_set = 1'b0; restart_set = 1'b0; stop_set = 1'b0;
    endtask

    task automatic clear_flags(input logic [2:0] m);
        @(negedge clk);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic wait_ops(input int n);
        while (ops_seen < n) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // byte engine model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req) begin
                exp_t e;
                string t;
                ops_seen++;
                if (expq.size() == 0) begin
                    check(1'b0, "R1/R3/R7", "unexpected engine op", {29'd0, eng_op}, 32'hff);
                    e = '0;
                end else begin
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check(eng_op == e.op, t, "engine op", {29'd0, eng_op}, {29'd0, e.op});
                    if (e.op == 3'd3)
                        check(eng_wdata == e.data, t, "write byte", {24'd0, eng_wdata}, {24'd0, e.data});
                    if (e.op == 3'd4)
                        check(eng_ack == e.ack, t, "read ack", {31'd0, eng_ack}, {31'd0, e.ack});
                end
                repeat (2) @(negedge clk);
                eng_done = 1'b1; eng_nack = e.nack; eng_rdata = e.rdata;
                @(negedge clk);
                eng_done = 1'b0; eng_nack = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(!eng_req, "R1", "reset eng_req", {31'd0, eng_req}, 0);
        check({cmd_start, cmd_restart, cmd_stop} == 3'b000, "R5", "reset cmd bits",
              {29'd0, cmd_start, cmd_restart, cmd_stop}, 0);
        check({done_flag, addr_ack_flag, err_flag} == 3'b000, "R12", "reset flags",
              {29'd0, done_flag, addr_ack_flag, err_flag}, 0);

        // S1: write with busy bus, empty-FIFO pause, then stop
        bus_busy = 1'b1;
        push_tx(8'hA4); push_tx(8'h11); push_tx(8'h22);
        expect_op(3'd0, 8'h00, 1'b0, 1'b0, 8'h00, "R1");
        expect_op(3'd3, 8'hA4, 1'b0, 1'b0, 8'h00, "R9");
        expect_op(3'd3, 8'h11, 1'b0, 1'b0, 8'h00, "R7");
        expect_op(3'd3, 8'h22, 1'b0, 1'b0, 8'h00, "R7");
        expect_op(3'd3, 8'h33, 1'b0, 1'b0, 8'h00, "R7");
        expect_op(3'd2, 8'h00, 1'b0, 1'b0, 8'h00, "R8");
        pulse_cmd(1'b1, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        check(ops_seen == 0, "R1", "ops while bus busy", ops_seen, 0);
        check(cmd_start, "R1", "start pending while busy", {31'd0, cmd_start}, 1);
        bus_busy = 1'b0;
        wait_ops(4);
        repeat (20) @(negedge clk);
        check(ops_seen == 4, "R7", "ops during empty pause", ops_seen, 4);
        check(!done_flag, "R7", "done during pause", {31'd0, done_flag}, 0);
        check(cmd_start, "R5", "start held during pause", {31'd0, cmd_start}, 1);
        push_tx(8'h33);
        wait_ops(5);
        check(ops_seen == 5, "R7", "ops after refill", ops_seen, 5);
        pulse_cmd(1'b0, 1'b0, 1'b1);
        wait_ops(6);
        check(!cmd_start && !cmd_stop, "R5", "bits after stop",
              {30'd0, cmd_start, cmd_stop}, 0);
        check(done_flag, "R8", "done after drain", {31'd0, done_flag}, 1);
        check(addr_ack_flag, "R9", "address ack flag", {31'd0, addr_ack_flag}, 1);
        check(!err_flag, "R11", "no error", {31'd0, err_flag}, 0);
        clear_flags(3'b001);
        check(!done_flag && addr_ack_flag, "R12", "selective clear",
              {30'd0, done_flag, addr_ack_flag}, 32'h1);
        clear_flags(3'b111);
        check({done_flag, addr_ack_flag, err_flag} == 3'b000, "R12", "clear all",
              {29'd0, done_flag, addr_ack_flag, err_flag}, 0);

        // S2: all three bits at once; read 3 then write after repeated START
        rx_count = 4'd3;
        push_tx(8'h51); push_tx(8'h52); push_tx(8'h77);
        expect_op(3'd0, 8'h00, 1'b0, 1'b0, 8'h00, "R4");
        expect_op(3'd3, 8'h51, 1'b0, 1'b0, 8'h00, "R9");
        expect_op(3'd4, 8'h00, 1'b1, 1'b0, 8'hC1, "R6");
        expect_op(3'd4, 8'h00, 1'b1, 1'b0, 8'hC2, "R6");
        expect_op(3'd4, 8'h00, 1'b0, 1'b0, 8'hC3, "R6");
        expect_op(3'd1, 8'h00, 1'b0, 1'b0, 8'h00, "R2");
        expect_op(3'd3, 8'h52, 1'b0, 1'b0, 8'h00, "R2");
        expect_op(3'd3, 8'h77, 1'b0, 1'b0, 8'h00, "R7");
        pulse_cmd(1'b1, 1'b1, 1'b1);
        wait_ops(14);
        repeat (20) @(negedge clk);
        check(ops_seen == 14, "R4", "no stop after first transaction", ops_seen, 14);
        check(cmd_start && !cmd_restart && !cmd_stop, "R4", "bits after repeated start",
              {29'd0, cmd_start, cmd_restart, cmd_stop}, 32'h4);
        check(rxn == 3, "R6", "bytes received", rxn, 3);
        check(rxlog[0] == 8'hC1 && rxlog[1] == 8'hC2 && rxlog[2] == 8'hC3, "R6", "rx bytes",
              {8'd0, rxlog[0], rxlog[1], rxlog[2]}, 32'hC1C2C3);
        check(done_flag, "R6", "done after last read", {31'd0, done_flag}, 1);
        expect_op(3'd2, 8'h00, 1'b0, 1'b0, 8'h00, "R5");
        pulse_cmd(1'b0, 1'b0, 1'b1);
        wait_ops(15);
        check(!cmd_start, "R5", "start cleared by stop", {31'd0, cmd_start}, 0);
        clear_flags(3'b111);

        // S3: restart and stop together; then a count-0 read
        push_tx(8'h20); push_tx(8'h01);
        expect_op(3'd0, 8'h00, 1'b0, 1'b0, 8'h00, "R3");
        expect_op(3'd3, 8'h20, 1'b0, 1'b0, 8'h00, "R3");
        expect_op(3'd3, 8'h01, 1'b0, 1'b0, 8'h00, "R3");
        expect_op(3'd1, 8'h00, 1'b0, 1'b0, 8'h00, "R3");
        pulse_cmd(1'b1, 1'b0, 1'b0);
        wait_ops(18);
        check(!done_flag, "R7", "no done before restart/stop", {31'd0, done_flag}, 0);
        pulse_cmd(1'b0, 1'b1, 1'b1);
        wait_ops(19);
        repeat (10) @(negedge clk);
        check(ops_seen == 19, "R3", "no stop with restart", ops_seen, 19);
        check(!cmd_restart && !cmd_stop && cmd_start, "R3", "bits after repeated start",
              {29'd0, cmd_start, cmd_restart, cmd_stop}, 32'h4);
        check(done_flag, "R8", "done on drain", {31'd0, done_flag}, 1);
        clear_flags(3'b111);
        rx_count = 4'd0;
        expect_op(3'd3, 8'h23, 1'b0, 1'b0, 8'h00, "R6");
        push_tx(8'h23);
        wait_ops(20);
        repeat (10) @(negedge clk);
        check(ops_seen == 20, "R6", "no reads for count 0", ops_seen, 20);
        check(rxn == 3, "R6", "rx unchanged for count 0", rxn, 3);
        check(done_flag && addr_ack_flag, "R6", "done after address for count 0",
              {30'd0, done_flag, addr_ack_flag}, 32'h3);
        expect_op(3'd2, 8'h00, 1'b0, 1'b0, 8'h00, "R8");
        pulse_cmd(1'b0, 1'b0, 1'b1);
        wait_ops(21);
        check(!cmd_start, "R5", "start cleared", {31'd0, cmd_start}, 0);
        clear_flags(3'b111);

        // S4: address NACK
        push_tx(8'h40); push_tx(8'h55);
        expect_op(3'd0, 8'h00, 1'b0, 1'b0, 8'h00, "R11");
        expect_op(3'd3, 8'h40, 1'b0, 1'b1, 8'h00, "R11");
        expect_op(3'd2, 8'h00, 1'b0, 1'b0, 8'h00, "R11");
        pulse_cmd(1'b1, 1'b0, 1'b0);
        wait_ops(24);
        repeat (10) @(negedge clk);
        check(ops_seen == 24, "R11", "no bytes after nack", ops_seen, 24);
        check(err_flag, "R11", "error flag", {31'd0, err_flag}, 1);
        check(!addr_ack_flag, "R9", "no address ack on nack", {31'd0, addr_ack_flag}, 0);
        check({cmd_start, cmd_restart, cmd_stop} == 3'b000, "R11", "bits after error stop",
              {29'd0, cmd_start, cmd_restart, cmd_stop}, 0);
        clear_flags(3'b100);
        check(!err_flag, "R12", "error cleared", {31'd0, err_flag}, 0);

        // S5: master mode off
        bus_busy = 1'b1;
        pulse_cmd(1'b1, 1'b1, 1'b1);
        check(cmd_start && cmd_restart && cmd_stop, "R10", "bits set with master on",
              {29'd0, cmd_start, cmd_restart, cmd_stop}, 32'h7);
        @(negedge clk);
        master_en = 1'b0;
        repeat (2) @(negedge clk);
        check({cmd_start, cmd_restart, cmd_stop} == 3'b000, "R10", "bits forced clear",
              {29'd0, cmd_start, cmd_restart, cmd_stop}, 0);
        pulse_cmd(1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check({cmd_start, cmd_restart, cmd_stop} == 3'b000, "R10", "sets ignored",
              {29'd0, cmd_start, cmd_restart, cmd_stop}, 0);
        master_en = 1'b1;
        bus_busy = 1'b0;
        repeat (20) @(negedge clk);
        check(ops_seen == 24, "R10", "no transfer after ignored set", ops_seen, 24);

        finish_run();
    end
endmodule